// File: doc/BRIEF.md
# Wrapped-Order Cache Line Fill Engine

This unit fills a single cache line whose width exceeds the memory bus, so the line arrives as a burst of several beats. When a fill is requested, the unit records the line address and the index of the chunk that holds the word the processor is waiting for. It then asks memory for a burst that begins at that chunk. As beats arrive, it writes each one into the line buffer in wrapped order: from the critical chunk up to the top of the line, then on from chunk 0.

The processor does not have to wait for the whole line. A restart pulse frees it as soon as the first beat, which carries the critical chunk, has been written. The other chunks keep streaming in behind it. A per-chunk presence map lets a later access to the same line find out whether its chunk has landed. If it has not, that access is told to stall. The line is marked valid only once every chunk is in. A one-cycle completion pulse then returns the unit to idle.

Top module: `ccf_fill_engine`

## Requirements
- R1: After reset the unit is idle. `busy`, `line_valid`, `restart`, `fill_done`, `mem_start` and `lb_we` are all 0, and a probe of any chunk reports a stall.
- R2: A request seen while idle is accepted at that clock edge. For the next cycle only, `busy` rises and `mem_start` pulses high. During that pulse `mem_line_addr` carries the requested line address and `mem_first_chunk` carries the requested critical chunk index.
- R3: Beat k of a fill (k = 0 for the first beat) is written to chunk index (critical + k) mod CHUNKS. Index 0 is the lowest-addressed chunk of the line. The write goes out on the same cycle the beat is presented, with `lb_wdata` equal to `beat_data`. Cycles in which `beat_valid` is low do not advance the order.
- R4: `restart` pulses high for exactly one cycle per fill, in the cycle after the first beat is accepted.
- R5: `probe_stall` equals `probe_valid` AND NOT present[probe_chunk]. Every chunk's present flag clears when a fill is accepted. A chunk's flag sets at the edge where its beat is written.
- R6: `line_valid` is 0 from the cycle after a fill is accepted until the final beat is written. It becomes 1 in the cycle after the final beat and stays 1 while the unit is idle.
- R7: `fill_done` is high for exactly one cycle, the cycle after the final beat. In that same cycle `busy` is already 0.
- R8: A request presented while `busy` is high is ignored. No new `mem_start` pulse appears, and neither the line address nor the write order changes.
- R9: `beat_valid` while idle is ignored. It produces no line-buffer write and leaves the present flags and `line_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request |
| req_line_addr | input | LINE_AW | Line address to fill |
| req_chunk | input | IDX_W | Index of the critical chunk |
| busy | output | 1 | Fill in progress |
| mem_start | output | 1 | One-cycle burst start to memory |
| mem_line_addr | output | LINE_AW | Line address of the burst |
| mem_first_chunk | output | IDX_W | Chunk at which the burst begins |
| beat_valid | input | 1 | Memory beat present |
| beat_data | input | CHUNK_W | Memory beat payload |
| lb_we | output | 1 | Line-buffer write enable |
| lb_idx | output | IDX_W | Chunk index being written |
| lb_wdata | output | CHUNK_W | Chunk data being written |
| restart | output | 1 | Early-restart pulse for the waiting access |
| fill_done | output | 1 | One-cycle completion pulse |
| line_valid | output | 1 | Whole line present |
| probe_valid | input | 1 | Later access asks about a chunk |
| probe_chunk | input | IDX_W | Chunk index of the later access |
| probe_stall | output | 1 | Later access must wait |

## Verification
The bench starts fills at every critical index. This includes the last chunk, whose order has to wrap at once to 0. A design that wraps at the wrong point, or that always starts at chunk 0, writes to the wrong index, and the scoreboard catches it. Beats are spread out with idle gaps, so a counter that advances on every clock instead of on every beat puts data in the wrong slot.

Around each beat, the bench probes the chunk that beat is about to fill. A presence map that sets too early, too late or not at all shows up as a wrong stall value. The bench also checks that restart pulses once, on the first beat only, and that done and line-valid appear on the final edge and no earlier. It sends requests during a fill and beats while idle. A design that accepted either would show a second burst start, a changed address, or an unexpected write.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/ccf_wrap_seq.sv
// Produces the wrapped chunk order of one burst and tracks the beat count.
module ccf_wrap_seq #(
    parameter int CHUNKS = 4,
    parameter int IDX_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             advance,
    output logic [IDX_W-1:0] cur_idx,
    output logic             is_first,
    output logic             is_last
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(CHUNKS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (load) begin
            seq_d.idx = start_idx;
            seq_d.cnt = '0;
        end else if (advance) begin
            seq_d.idx = (seq_q.idx == TOP) ? '0 : seq_q.idx + 1'b1;
            seq_d.cnt = (seq_q.cnt == TOP) ? '0 : seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign cur_idx  = seq_q.idx;
    assign is_first = (seq_q.cnt == '0);
    assign is_last  = (seq_q.cnt == TOP);

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_idx) < CHUNKS);
    assert_first_is_critical_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_idx == $past(start_idx)) && is_first);
endmodule

// File: rtl/ccf_arrival_map.sv
// One presence flag per chunk; answers probes from later accesses.
module ccf_arrival_map #(
    parameter int CHUNKS = 4,
    parameter int IDX_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             present
);
    logic [CHUNKS-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clear) begin
            flags_d = '0;
        end else if (set_en) begin
            for (int i = 0; i < CHUNKS; i++) begin
                if (set_idx == IDX_W'(i)) flags_d[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign present = flags_q[probe_idx];

    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (flags_q == '0));
    assert_set_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clear) |=> flags_q[$past(set_idx)]);
endmodule

// File: rtl/ccf_fill_engine.sv
// Critical-chunk-first line fill control.
module ccf_fill_engine #(
    parameter int LINE_AW = 26,
    parameter int CHUNK_W = 32,
    parameter int CHUNKS  = 4,
    parameter int IDX_W   = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [LINE_AW-1:0] req_line_addr,
    input  logic [IDX_W-1:0]   req_chunk,
    output logic               busy,
    output logic               mem_start,
    output logic [LINE_AW-1:0] mem_line_addr,
    output logic [IDX_W-1:0]   mem_first_chunk,
    input  logic               beat_valid,
    input  logic [CHUNK_W-1:0] beat_data,
    output logic               lb_we,
    output logic [IDX_W-1:0]   lb_idx,
    output logic [CHUNK_W-1:0] lb_wdata,
    output logic               restart,
    output logic               fill_done,
    output logic               line_valid,
    input  logic               probe_valid,
    input  logic [IDX_W-1:0]   probe_chunk,
    output logic               probe_stall
);
    import ccf_pkg::*;

    typedef struct packed {
        fill_state_e        state;
        logic [LINE_AW-1:0] addr;
        logic [IDX_W-1:0]   crit;
        logic               start;
        logic               rst_pulse;
        logic               done;
        logic               valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             accept, beat_fire;
    logic [IDX_W-1:0] cur_idx;
    logic             is_first, is_last, present;

    assign accept    = (ctl_q.state == ST_IDLE) && req_valid;
    assign beat_fire = (ctl_q.state == ST_FILL) && beat_valid;

    ccf_wrap_seq #(.CHUNKS(CHUNKS), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .start_idx(req_chunk),
        .advance  (beat_fire),
        .cur_idx  (cur_idx),
        .is_first (is_first),
        .is_last  (is_last)
    );

    ccf_arrival_map #(.CHUNKS(CHUNKS), .IDX_W(IDX_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .set_en   (beat_fire),
        .set_idx  (cur_idx),
        .probe_idx(probe_chunk),
        .present  (present)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.start     = accept;
        ctl_d.rst_pulse = beat_fire && is_first;
        ctl_d.done      = beat_fire && is_last;
        if (accept) begin
            ctl_d.state = ST_FILL;
            ctl_d.addr  = req_line_addr;
            ctl_d.crit  = req_chunk;
            ctl_d.valid = 1'b0;
        end else if (beat_fire && is_last) begin
            ctl_d.state = ST_IDLE;
            ctl_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy            = (ctl_q.state == ST_FILL);
    assign mem_start       = ctl_q.start;
    assign mem_line_addr   = ctl_q.addr;
    assign mem_first_chunk = ctl_q.crit;
    assign lb_we           = beat_fire;
    assign lb_idx          = cur_idx;
    assign lb_wdata        = beat_data;
    assign restart         = ctl_q.rst_pulse;
    assign fill_done       = ctl_q.done;
    assign line_valid      = ctl_q.valid;
    assign probe_stall     = probe_valid && !present;

    assert_start_in_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |-> busy);
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |=> !mem_start);
    assert_restart_after_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> $past(lb_we));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (!busy && line_valid));
    assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> !busy);
    assert_busy_holds_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fill_done) |=> $stable(mem_line_addr) || !busy);
    assert_no_idle_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !lb_we);
endmodule

// File: tb/ccf_fill_engine_tb.sv
module ccf_fill_engine_tb;
    localparam int LINE_AW = 26;
    localparam int CHUNK_W = 32;
    localparam int CHUNKS  = 4;
    localparam int IDX_W   = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [LINE_AW-1:0] req_line_addr = '0;
    logic [IDX_W-1:0]   req_chunk = '0;
    logic               busy, mem_start;
    logic [LINE_AW-1:0] mem_line_addr;
    logic [IDX_W-1:0]   mem_first_chunk;
    logic               beat_valid = 1'b0;
    logic [CHUNK_W-1:0] beat_data = '0;
    logic               lb_we;
    logic [IDX_W-1:0]   lb_idx;
    logic [CHUNK_W-1:0] lb_wdata;
    logic               restart, fill_done, line_valid;
    logic               probe_valid = 1'b0;
    logic [IDX_W-1:0]   probe_chunk = '0;
    logic               probe_stall;

    int total = 0;
    int bad = 0;
    int starts_seen = 0;
    logic [IDX_W+CHUNK_W-1:0] expq[$];

    always #5 clk = ~clk;

    ccf_fill_engine #(.LINE_AW(LINE_AW), .CHUNK_W(CHUNK_W), .CHUNKS(CHUNKS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_line_addr(req_line_addr), .req_chunk(req_chunk),
        .busy(busy), .mem_start(mem_start), .mem_line_addr(mem_line_addr),
        .mem_first_chunk(mem_first_chunk),
        .beat_valid(beat_valid), .beat_data(beat_data),
        .lb_we(lb_we), .lb_idx(lb_idx), .lb_wdata(lb_wdata),
        .restart(restart), .fill_done(fill_done), .line_valid(line_valid),
        .probe_valid(probe_valid), .probe_chunk(probe_chunk), .probe_stall(probe_stall)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [CHUNK_W-1:0] mkdata(input int addr, input int idx);
        return CHUNK_W'(addr * 16 + idx) ^ 32'h5A5A_0000;
    endfunction

    // Monitor: samples 2 ns after each falling edge, after the driver has settled.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mem_start) starts_seen++;
            if (lb_we) begin
                if (expq.size() == 0) begin
                    check("R9", "unexpected write", 1, 0);
                end else begin
                    logic [IDX_W+CHUNK_W-1:0] e;
                    e = expq.pop_front();
                    check("R3", "write index", lb_idx, e[IDX_W+CHUNK_W-1:CHUNK_W]);
                    check("R3", "write data", lb_wdata, e[CHUNK_W-1:0]);
                end
            end
        end
    end

    task automatic do_fill(input int addr, input int crit, input int gap);
        int starts_before;
        @(negedge clk);
        starts_before = starts_seen;
        req_valid = 1'b1; req_line_addr = LINE_AW'(addr); req_chunk = IDX_W'(crit);
        @(negedge clk);
        // Competing request during the fill (R8)
        req_line_addr = LINE_AW'(addr + 7); req_chunk = IDX_W'(crit + 1);
        check("R2", "busy", busy, 1);
        check("R2", "mem_start", mem_start, 1);
        check("R2", "mem_line_addr", mem_line_addr, addr);
        check("R2", "mem_first_chunk", mem_first_chunk, crit);
        check("R6", "line_valid during fill", line_valid, 0);
        for (int k = 0; k < CHUNKS; k++) begin
            int idx;
            idx = (crit + k) % CHUNKS;
            expq.push_back({IDX_W'(idx), mkdata(addr, idx)});
            beat_valid = 1'b1; beat_data = mkdata(addr, idx);
            probe_valid = 1'b1; probe_chunk = IDX_W'(idx);
            #1;
            check("R5", "stall before chunk", probe_stall, 1);
            @(negedge clk);
            beat_valid = 1'b0;
            #1;
            check("R5", "stall after chunk", probe_stall, 0);
            check("R4", "restart", restart, (k == 0) ? 1 : 0);
            check("R7", "fill_done", fill_done, (k == CHUNKS - 1) ? 1 : 0);
            check("R6", "line_valid", line_valid, (k == CHUNKS - 1) ? 1 : 0);
            check("R8", "addr held", mem_line_addr, addr);
            if (k == CHUNKS - 1) begin
                req_valid = 1'b0;
                check("R7", "busy after last", busy, 0);
            end
            for (int g = 0; g < gap && k < CHUNKS - 1; g++) @(negedge clk);
        end
        probe_valid = 1'b0;
        @(negedge clk);
        #1;
        check("R7", "done one cycle", fill_done, 0);
        check("R6", "line_valid held", line_valid, 1);
        check("R8", "single start per fill", starts_seen - starts_before, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        probe_valid = 1'b1; probe_chunk = '0;
        #1;
        check("R1", "busy", busy, 0);
        check("R1", "line_valid", line_valid, 0);
        check("R1", "restart", restart, 0);
        check("R1", "fill_done", fill_done, 0);
        check("R1", "mem_start", mem_start, 0);
        check("R1", "lb_we", lb_we, 0);
        check("R1", "probe stall", probe_stall, 1);
        probe_valid = 1'b0;

        do_fill(32'h100, 0, 0);
        do_fill(32'h2A3, 2, 1);
        do_fill(32'h3FF, 3, 2);
        do_fill(32'h044, 1, 0);

        // R9: beats while idle are ignored
        @(negedge clk);
        beat_valid = 1'b1; beat_data = 32'hDEAD_BEEF;
        repeat (2) @(negedge clk);
        beat_valid = 1'b0;
        #1;
        check("R9", "line_valid kept", line_valid, 1);
        for (int c = 0; c < CHUNKS; c++) begin
            probe_valid = 1'b1; probe_chunk = IDX_W'(c);
            #1;
            check("R9", "chunk still present", probe_stall, 0);
        end
        probe_valid = 1'b0;
        check("R9", "no idle start", mem_start, 0);
        repeat (2) @(negedge clk);
        check("R3", "queue drained", expq.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule